// File: doc/BRIEF.md
# MSI-X Vector Table and Pending Controller

This block holds the per-vector message table and the pending-bit array of one PCI function that signals interrupts through MSI-X. Software reaches both structures through one 32-bit register port that decodes a 4 KiB window. The vector table sits at the bottom of the window. The pending-bit array sits at offset 0x800 and software can only read it. Two level inputs carry the enable and function-wide mask state of the capability.

Device logic raises a one-cycle trigger on a vector. Device logic also counts up and down how many of its sources use each vector. A trigger on an in-use vector that is not masked leaves as one message: a 64-bit address and 32-bit data taken from that vector's table entry, offered on a valid/ready output. A trigger on a masked vector is recorded as pending instead. It is replayed once the vector becomes unmasked, either through a write to its own control word or through the function-level mask clearing. In the second case every vector is re-evaluated.

Top module: `msix_vector_ctrl`

## Requirements
- R1: After reset every address, data and control word of the table reads zero except bit 0 of each control word, which reads one; the pending array reads zero and `msg_valid` is low.
- R2: Entry v occupies window offsets 16*v to 16*v+15, holding the address low word at +0, the address high word at +4, the data word at +8 and the control word at +12. Only bit 0 of the control word is stored (the vector mask); bits 31:1 read zero. Address bits above bit 11 and bits 1:0 are ignored, and `reg_rdata` holds the addressed word in the cycle after `reg_rd`.
- R3: A write whose entry index (offset / 16) is NUM_VEC or above has no effect. This covers every write into the pending array at 0x800. Reads of such table offsets return zero.
- R4: The word at offset 0x800 carries the pending bit of vector v at bit v (byte v/8, bit v mod 8, little-endian). All other words of the pending array read zero.
- R5: A trigger on a vector that is in use and unmasked produces exactly one message with `msg_addr` = {address high, address low} and `msg_data` = the data word of that entry.
- R6: A vector is masked when its control mask bit is set, when `cap_enable` is low or when `cap_mask_all` is high. A trigger on a masked, in-use vector sets its pending bit and produces no message.
- R7: Each vector keeps a saturating use count, raised by `vec_use_inc` and lowered by `vec_use_dec` (no change when both are high or when lowering at zero). A trigger on a vector with count zero is dropped. A decrement that brings the count to zero clears the vector's pending bit.
- R8: A control-word write that takes a vector from masked to unmasked while its pending bit is set clears the bit and produces that vector's message once.
- R9: When the function mask goes from set to clear, every pending vector whose own mask bit is clear is replayed and its pending bit cleared. Pending vectors whose own mask bit is set stay pending.
- R10: `msg_valid`, `msg_addr` and `msg_data` hold steady until `msg_ready` accepts them. At most one message leaves per cycle. When several vectors are owed at once, they leave in ascending vector order.
- R11: A trigger on a vector whose pending bit is already set adds no further message; the bit is replayed once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe (32-bit access) |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 32 | Byte address; reduced to the 4 KiB window, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| cap_enable | input | 1 | Capability enable level |
| cap_mask_all | input | 1 | Function-wide mask level |
| vec_trig | input | NUM_VEC | One-cycle interrupt trigger per vector |
| vec_use_inc | input | NUM_VEC | Raise the use count of a vector |
| vec_use_dec | input | NUM_VEC | Lower the use count of a vector |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted when high with `msg_valid` |
| msg_addr | output | 64 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The assertions take for granted that reset is held low across at least one clock edge, and that trigger and use inputs are single-cycle pulses per vector. `msg_ready` may behave arbitrarily. The stimulus spaces each operation by more cycles than a full replay of all vectors takes. Under that spacing a new trigger never lands on a vector that still awaits its output slot, so a simple per-vector message-count model matches the hardware exactly. Back-pressure is applied only in a directed case, where the ascending release order and the held payload are checked.

// File: rtl/msix_pkg.sv
// Shared constants and types for the MSI-X vector controller.
// Assumes a 4 KiB window with 16-byte table entries and the pending array at 0x800.
package msix_pkg;
    localparam int MAX_VECTORS = 32;
    localparam int ENTRY_WORDS = 4;

    // Word position inside one table entry; the order is software visible.
    typedef enum logic [1:0] {
        WORD_ADDR_LO = 2'd0,
        WORD_ADDR_HI = 2'd1,
        WORD_DATA    = 2'd2,
        WORD_CTRL    = 2'd3
    } entry_word_e;

    // Width of a vector index for a given vector count (at least one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/msix_table.sv
// Vector table storage: address, data and mask bit for each implemented vector.
// Decodes word writes, serves a combinational read word and the payload of one
// selected vector. Assumes wr_wa/rd_wa are word addresses inside the 4 KiB window.
module msix_table import msix_pkg::*; #(
    parameter int NUM_VEC = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [9:0]                    wr_wa,
    input  logic [31:0]                   wr_data,
    input  logic [9:0]                    rd_wa,
    output logic [31:0]                   rd_word,
    input  logic [idx_width(NUM_VEC)-1:0] sel_idx,
    output logic [63:0]                   sel_addr,
    output logic [31:0]                   sel_data,
    output logic [NUM_VEC-1:0]            mask_o
);
    localparam int         IDX_W = idx_width(NUM_VEC);
    localparam logic [7:0] NV8   = 8'(NUM_VEC);

    logic [31:0]        lo_q  [NUM_VEC];
    logic [31:0]        hi_q  [NUM_VEC];
    logic [31:0]        dat_q [NUM_VEC];
    logic [NUM_VEC-1:0] mask_q;

    // Reset clears the table and masks every vector; writes land on in-range entries only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < NUM_VEC; v++) begin
                lo_q[v]  <= '0;
                hi_q[v]  <= '0;
                dat_q[v] <= '0;
            end
            mask_q <= '1;
        end else if (wr_en) begin
            for (int v = 0; v < NUM_VEC; v++) begin
                if (wr_wa[9:2] == 8'(v)) begin
                    case (wr_wa[1:0])
                        WORD_ADDR_LO: lo_q[v]  <= wr_data;
                        WORD_ADDR_HI: hi_q[v]  <= wr_data;
                        WORD_DATA:    dat_q[v] <= wr_data;
                        default:      mask_q[v] <= wr_data[0];
                    endcase
                end
            end
        end
    end

    // Software read of one table word; out-of-range entries read zero.
    always_comb begin
        rd_word = '0;
        if (rd_wa[9:2] < NV8) begin
            case (rd_wa[1:0])
                WORD_ADDR_LO: rd_word = lo_q[rd_wa[IDX_W+1:2]];
                WORD_ADDR_HI: rd_word = hi_q[rd_wa[IDX_W+1:2]];
                WORD_DATA:    rd_word = dat_q[rd_wa[IDX_W+1:2]];
                default:      rd_word = {31'd0, mask_q[rd_wa[IDX_W+1:2]]};
            endcase
        end
    end

    // Payload of the vector chosen by the dispatcher.
    always_comb begin
        sel_addr = {hi_q[sel_idx], lo_q[sel_idx]};
        sel_data = dat_q[sel_idx];
    end

    assign mask_o = mask_q;

    // R1
    reset_mask_chk: assert property (@(posedge clk) !rst_n |=> (mask_o == '1));

    // R3
    pba_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_wa[9]) |=> $stable(mask_o));
endmodule

// File: rtl/msix_pending.sv
// Pending bits and per-vector use counters.
// A pending bit means "a message is owed": it is set by an accepted trigger and
// cleared when the dispatcher launches the vector or its use count reaches zero.
// Assumes trig/use inputs are single-cycle pulses.
module msix_pending import msix_pkg::*; #(
    parameter int NUM_VEC = 32,
    parameter int CNT_W   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_VEC-1:0]            trig,
    input  logic [NUM_VEC-1:0]            use_inc,
    input  logic [NUM_VEC-1:0]            use_dec,
    input  logic [NUM_VEC-1:0]            vmask,
    input  logic                          launch,
    input  logic [idx_width(NUM_VEC)-1:0] launch_idx,
    output logic [NUM_VEC-1:0]            pend
);
    localparam int               IDX_W   = idx_width(NUM_VEC);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0]   cnt_q [NUM_VEC];
    logic [NUM_VEC-1:0] pend_q;
    logic [NUM_VEC-1:0] used;
    logic [NUM_VEC-1:0] drop;
    logic [NUM_VEC-1:0] hold_set;

    // Decode in-use state and the last-user release of each vector.
    always_comb begin
        for (int v = 0; v < NUM_VEC; v++) begin
            used[v] = (cnt_q[v] != '0);
            drop[v] = (cnt_q[v] == CNT_W'(1)) && use_dec[v] && !use_inc[v];
        end
    end

    // Saturating use counters and owed-message bits; release beats set beats launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < NUM_VEC; v++) cnt_q[v] <= '0;
            pend_q <= '0;
        end else begin
            for (int v = 0; v < NUM_VEC; v++) begin
                if (use_inc[v] && !use_dec[v] && cnt_q[v] != CNT_MAX)
                    cnt_q[v] <= cnt_q[v] + 1'b1;
                else if (use_dec[v] && !use_inc[v] && cnt_q[v] != '0)
                    cnt_q[v] <= cnt_q[v] - 1'b1;

                if (drop[v])
                    pend_q[v] <= 1'b0;
                else if (trig[v] && used[v])
                    pend_q[v] <= 1'b1;
                else if (launch && launch_idx == IDX_W'(v))
                    pend_q[v] <= 1'b0;
            end
        end
    end

    assign pend     = pend_q;
    assign hold_set = trig & vmask & used & ~drop;

    // R7
    pend_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~used) == '0));

    // R6
    masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hold_set) |=> ((pend & $past(hold_set)) == $past(hold_set)));
endmodule

// File: rtl/msix_dispatch.sv
// Picks the lowest-numbered owed, unmasked vector and offers its message on a
// valid/ready output register. Assumes the payload inputs follow sel_idx in the
// same cycle.
module msix_dispatch import msix_pkg::*; #(
    parameter int NUM_VEC = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_VEC-1:0]            eligible,
    output logic [idx_width(NUM_VEC)-1:0] sel_idx,
    input  logic [63:0]                   sel_addr,
    input  logic [31:0]                   sel_data,
    output logic                          launch,
    output logic                          msg_valid,
    input  logic                          msg_ready,
    output logic [63:0]                   msg_addr,
    output logic [31:0]                   msg_data
);
    localparam int IDX_W = idx_width(NUM_VEC);

    logic any_owed;

    // Priority pick: the descending scan leaves the lowest eligible index.
    always_comb begin
        sel_idx  = '0;
        any_owed = 1'b0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                sel_idx  = IDX_W'(i);
                any_owed = 1'b1;
            end
        end
    end

    assign launch = any_owed && (!msg_valid || msg_ready);

    // Output register: load on launch, drop valid once accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
        end else if (launch) begin
            msg_valid <= 1'b1;
            msg_addr  <= sel_addr;
            msg_data  <= sel_data;
        end else if (msg_ready) begin
            msg_valid <= 1'b0;
        end
    end

    // R10
    msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
endmodule

// File: rtl/msix_vector_ctrl.sv
// MSI-X vector table, pending array and message dispatch for one function.
// Ties the table, the pending/use state and the dispatcher together, forms the
// per-vector mask and serves software reads of table and pending words.
// Assumes 32-bit accesses only and 1 <= NUM_VEC <= 32.
module msix_vector_ctrl import msix_pkg::*; #(
    parameter int NUM_VEC = 32,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [31:0]        reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               cap_enable,
    input  logic               cap_mask_all,
    input  logic [NUM_VEC-1:0] vec_trig,
    input  logic [NUM_VEC-1:0] vec_use_inc,
    input  logic [NUM_VEC-1:0] vec_use_dec,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data
);
    localparam int IDX_W = idx_width(NUM_VEC);

    logic [9:0]         word_addr;
    logic               unused_addr_bits;
    logic               func_masked;
    logic [NUM_VEC-1:0] ctrl_mask;
    logic [NUM_VEC-1:0] vmask;
    logic [NUM_VEC-1:0] pend;
    logic [NUM_VEC-1:0] eligible;
    logic [31:0]        tbl_word;
    logic [IDX_W-1:0]   sel_idx;
    logic [63:0]        sel_addr;
    logic [31:0]        sel_data;
    logic               launch;

    assign word_addr        = reg_addr[11:2];
    assign unused_addr_bits = ^{reg_addr[31:12], reg_addr[1:0]};

    // Effective masks: function level ORed onto each vector's own bit.
    assign func_masked = !cap_enable || cap_mask_all;
    assign vmask       = ctrl_mask | {NUM_VEC{func_masked}};
    assign eligible    = pend & ~vmask;

    msix_table #(.NUM_VEC(NUM_VEC)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .wr_wa    (word_addr),
        .wr_data  (reg_wdata),
        .rd_wa    (word_addr),
        .rd_word  (tbl_word),
        .sel_idx  (sel_idx),
        .sel_addr (sel_addr),
        .sel_data (sel_data),
        .mask_o   (ctrl_mask)
    );

    msix_pending #(.NUM_VEC(NUM_VEC), .CNT_W(CNT_W)) u_pending (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig       (vec_trig),
        .use_inc    (vec_use_inc),
        .use_dec    (vec_use_dec),
        .vmask      (vmask),
        .launch     (launch),
        .launch_idx (sel_idx),
        .pend       (pend)
    );

    msix_dispatch #(.NUM_VEC(NUM_VEC)) u_dispatch (
        .clk       (clk),
        .rst_n     (rst_n),
        .eligible  (eligible),
        .sel_idx   (sel_idx),
        .sel_addr  (sel_addr),
        .sel_data  (sel_data),
        .launch    (launch),
        .msg_valid (msg_valid),
        .msg_ready (msg_ready),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data)
    );

    // Registered read: upper half of the window is the pending array, first word only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            if (word_addr[9])
                reg_rdata <= (word_addr[8:0] == '0) ? 32'(pend) : 32'd0;
            else
                reg_rdata <= tbl_word;
        end
    end
endmodule

// File: tb/msix_vector_ctrl_tb.sv
`timescale 1ns/1ps
module msix_vector_ctrl_tb;
    localparam int NV = 6;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0]   reg_addr = '0, reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          cap_enable = 1'b0, cap_mask_all = 1'b0;
    logic [NV-1:0] vec_trig = '0, vec_use_inc = '0, vec_use_dec = '0;
    logic          msg_valid;
    logic          msg_ready = 1'b1;
    logic [63:0]   msg_addr;
    logic [31:0]   msg_data;

    always #2 clk = ~clk;

    msix_vector_ctrl #(.NUM_VEC(NV), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cap_enable(cap_enable), .cap_mask_all(cap_mask_all),
        .vec_trig(vec_trig), .vec_use_inc(vec_use_inc), .vec_use_dec(vec_use_dec),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    int checks = 0, failures = 0, cyc = 0;
    bit m_mask [NV];
    bit m_pend [NV];
    int m_cnt  [NV];
    int exp_cnt[NV];
    int got_cnt[NV];
    bit m_en = 0, m_mall = 0;
    int seq_log[512];
    int seq_n = 0;

    function automatic bit m_fmask();
        return !m_en || m_mall;
    endfunction
    function automatic bit m_masked(int v);
        return m_fmask() || m_mask[v];
    endfunction
    function automatic logic [31:0] v_lo(int v);
        return 32'hFEE0_0000 + 32'(v * 16);
    endfunction
    function automatic logic [31:0] v_hi(int v);
        return 32'h0000_0100 + 32'(v);
    endfunction
    function automatic logic [31:0] v_dat(int v);
        return 32'hA5A5_0000 | 32'(v);
    endfunction
    function automatic logic [31:0] m_pba();
        logic [31:0] w = '0;
        for (int v = 0; v < NV; v++) w[v] = m_pend[v];
        return w;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask
    task automatic idle(input int n);
        repeat (n) step();
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        int v;
        bit was;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
        v = int'(a[11:4]);
        if (!a[11] && v < NV && a[3:2] == 2'd3) begin
            was = m_masked(v);
            m_mask[v] = d[0];
            if (was && !m_masked(v) && m_pend[v]) begin
                m_pend[v] = 0;
                exp_cnt[v]++;
            end
        end
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] q);
        reg_rd = 1'b1; reg_addr = a;
        step();
        reg_rd = 1'b0;
        @(negedge clk);
        q = reg_rdata;
    endtask

    task automatic set_cap(input bit en, input bit mall);
        bit was;
        was = m_fmask();
        cap_enable = en; cap_mask_all = mall;
        m_en = en; m_mall = mall;
        step();
        if (was && !m_fmask())
            for (int v = 0; v < NV; v++)
                if (m_pend[v] && !m_mask[v]) begin
                    m_pend[v] = 0;
                    exp_cnt[v]++;
                end
    endtask

    task automatic fire(input int v);
        vec_trig[v] = 1'b1;
        step();
        vec_trig = '0;
        if (m_cnt[v] > 0) begin
            if (m_masked(v)) m_pend[v] = 1;
            else exp_cnt[v]++;
        end
    endtask

    task automatic use_up(input int v);
        vec_use_inc[v] = 1'b1;
        step();
        vec_use_inc = '0;
        if (m_cnt[v] < (1 << CW) - 1) m_cnt[v]++;
    endtask

    task automatic use_dn(input int v);
        vec_use_dec[v] = 1'b1;
        step();
        vec_use_dec = '0;
        if (m_cnt[v] > 0) begin
            m_cnt[v]--;
            if (m_cnt[v] == 0) m_pend[v] = 0;
        end
    endtask

    task automatic check_counts(input string tag);
        for (int v = 0; v < NV; v++)
            chk(got_cnt[v] == exp_cnt[v], tag, 64'(got_cnt[v]), 64'(exp_cnt[v]));
    endtask

    task automatic check_pba(input string tag);
        logic [31:0] q;
        rd(32'h0000_0800, q);
        chk(q == m_pba(), tag, 64'(q), 64'(m_pba()));
    endtask

    // Message monitor: record each accepted message, check its payload (R5).
    always @(negedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            int v;
            v = int'(msg_data[7:0]);
            if (v < NV) begin
                chk(msg_data == v_dat(v) && msg_addr == {v_hi(v), v_lo(v)},
                    "R5 payload", msg_addr, {v_hi(v), v_lo(v)});
                got_cnt[v]++;
                if (seq_n < 512) seq_log[seq_n] = v;
                seq_n++;
            end else begin
                chk(1'b0, "R5 unknown vector", 64'(msg_data), 64'(0));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] q;
        logic [63:0] held_addr;
        logic [31:0] held_data;
        int s0;
        void'($urandom(32'd4242));
        for (int v = 0; v < NV; v++) begin
            m_mask[v] = 1; m_pend[v] = 0; m_cnt[v] = 0; exp_cnt[v] = 0; got_cnt[v] = 0;
        end
        idle(3);
        rst_n = 1'b1;
        step();

        // R1 reset state
        @(negedge clk);
        chk(msg_valid == 1'b0, "R1 msg_valid", 64'(msg_valid), 64'(0));
        for (int v = 0; v < NV; v++) begin
            rd(32'(v * 16 + 12), q);
            chk(q == 32'd1, "R1 ctrl mask", 64'(q), 64'(1));
        end
        rd(32'h0000_0020, q);
        chk(q == 32'd0, "R1 addr zero", 64'(q), 64'(0));
        check_pba("R1 pba zero");

        // R2 program and read back entries, including address aliasing
        for (int v = 0; v < NV; v++) begin
            wr(32'(v * 16 + 0), v_lo(v));
            wr(32'(v * 16 + 4), v_hi(v));
            wr(32'(v * 16 + 8), v_dat(v));
        end
        rd(32'h0000_0010, q);
        chk(q == v_lo(1), "R2 addr lo v1", 64'(q), 64'(v_lo(1)));
        rd(32'h0003_1027, q);
        chk(q == v_hi(2), "R2 alias hi v2", 64'(q), 64'(v_hi(2)));
        rd(32'h0000_0058, q);
        chk(q == v_dat(5), "R2 data v5", 64'(q), 64'(v_dat(5)));
        wr(32'h0000_004C, 32'hFFFF_FFFE);
        rd(32'h0000_004C, q);
        chk(q == 32'd0, "R2 ctrl upper bits", 64'(q), 64'(0));
        wr(32'h0000_004C, 32'h1);

        // R3 ignored writes
        wr(32'h0000_0800, 32'hFFFF_FFFF);
        check_pba("R3 pba write ignored");
        wr(32'(NV * 16 + 12), 32'd0);
        wr(32'(NV * 16 + 8), 32'h1234_5678);
        rd(32'(NV * 16 + 8), q);
        chk(q == 32'd0, "R3 out-of-range entry", 64'(q), 64'(0));
        rd(32'h0000_000C, q);
        chk(q == 32'd1, "R3 v0 ctrl untouched", 64'(q), 64'(1));
        rd(32'h0000_0804, q);
        chk(q == 32'd0, "R4 other pba word", 64'(q), 64'(0));

        // R7 trigger on unused vector dropped
        set_cap(1'b1, 1'b0);
        wr(32'h0000_000C, 32'd0);
        fire(0);
        idle(4);
        chk(got_cnt[0] == 0, "R7 unused trigger dropped", 64'(got_cnt[0]), 64'(0));
        for (int v = 0; v < NV; v++) use_up(v);

        // R5 direct message
        fire(0);
        idle(4);
        chk(got_cnt[0] == 1, "R5 one message", 64'(got_cnt[0]), 64'(1));

        // R6 masked trigger held, R4 pba bit position
        fire(3);
        idle(4);
        chk(got_cnt[3] == 0, "R6 no message when masked", 64'(got_cnt[3]), 64'(0));
        check_pba("R4 pba bit 3");

        // R8 replay on per-vector unmask
        wr(32'h0000_003C, 32'd0);
        idle(4);
        chk(got_cnt[3] == 1, "R8 replay", 64'(got_cnt[3]), 64'(1));
        check_pba("R8 pba cleared");

        // R9 / R11 function mask sweep with merging
        wr(32'h0000_001C, 32'd0);
        wr(32'h0000_002C, 32'd0);
        set_cap(1'b1, 1'b1);
        fire(1); fire(1); fire(2); fire(4);
        idle(4);
        check_pba("R6 pba under mask-all");
        chk(got_cnt[1] == 0, "R6 mask-all holds", 64'(got_cnt[1]), 64'(0));
        set_cap(1'b1, 1'b0);
        idle(NV + 4);
        chk(got_cnt[1] == 1, "R11 merged replay", 64'(got_cnt[1]), 64'(1));
        chk(got_cnt[2] == 1, "R9 sweep replay", 64'(got_cnt[2]), 64'(1));
        check_pba("R9 masked vector stays pending");
        set_cap(1'b0, 1'b0);
        fire(2);
        idle(4);
        chk(got_cnt[2] == 1, "R6 disabled holds", 64'(got_cnt[2]), 64'(1));
        set_cap(1'b1, 1'b0);
        idle(NV + 4);
        chk(got_cnt[2] == 2, "R9 enable replay", 64'(got_cnt[2]), 64'(2));

        // R7 last user release clears pending
        use_dn(4);
        check_pba("R7 release clears pending");
        use_up(4);

        // R10 back-pressure and ascending order
        msg_ready = 1'b0;
        set_cap(1'b1, 1'b1);
        fire(2); fire(0); fire(1);
        set_cap(1'b1, 1'b0);
        idle(4);
        @(negedge clk);
        chk(msg_valid == 1'b1 && msg_data == v_dat(0), "R10 lowest first", 64'(msg_data), 64'(v_dat(0)));
        held_addr = msg_addr; held_data = msg_data;
        idle(3);
        @(negedge clk);
        chk(msg_valid && msg_addr == held_addr && msg_data == held_data, "R10 held stable",
            64'(msg_data), 64'(held_data));
        s0 = seq_n;
        msg_ready = 1'b1;
        idle(NV + 4);
        chk(seq_n == s0 + 3, "R10 three released", 64'(seq_n), 64'(s0 + 3));
        chk(seq_log[s0] == 0 && seq_log[s0 + 1] == 1 && seq_log[s0 + 2] == 2, "R10 ascending",
            64'({seq_log[s0][7:0], seq_log[s0 + 1][7:0], seq_log[s0 + 2][7:0]}), 64'(24'h000102));
        check_counts("R10 counts");

        // Random phase: spaced operations checked against the bench model
        for (int i = 0; i < 250; i++) begin
            int op, v;
            op = int'($urandom % 6);
            v  = int'($urandom % NV);
            case (op)
                0, 1: fire(v);
                2:    wr(32'(v * 16 + 12), 32'($urandom % 2));
                3:    set_cap(($urandom % 4) != 0, ($urandom % 3) == 0);
                4:    use_up(v);
                default: use_dn(v);
            endcase
            idle(NV + 4);
            if (i % 50 == 49) begin
                check_pba("R4 random pba");
                check_counts("R8 R9 random counts");
            end
        end

        // Final drain: unmask everything, all owed messages must appear
        set_cap(1'b1, 1'b0);
        for (int v = 0; v < NV; v++) wr(32'(v * 16 + 12), 32'd0);
        idle(NV + 4);
        check_counts("R9 final counts");
        check_pba("R8 final pba");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule